// File: doc/BRIEF.md
# Syncable, Triggerable, Cascadable Capture Time Base

This block is the free-standing time base that a capture channel samples. It is an up-counter advanced by a one-cycle timer tick enable. It can run freely. It can be held clear by a level on a sync input. It can be started by a rising edge on that input, or by software, through a run latch. Two instances can be chained so that the upper one advances only when the lower one carries out.

All inputs are synchronous to one system clock. A 5-bit source select says whether a sync/trigger source is connected: a nonzero value means connected, zero means none. A mode bit chooses between level synchronization and edge triggering. A module-on input clears everything while it is low. The counter value, the run latch and a carry-out flag are brought out so that a neighbour instance or a capture stage can use them.

Top module: `cap_time_base`

## Requirements
- R1: The counter is CNT_W bits wide (default 16). When the module is on, trigger mode is 0 and the select is 0, it rises by one at each clock edge where `tmrTick` is 1. It holds when `tmrTick` is 0, and wraps from all ones to zero.
- R2: With trigger mode 0 and a nonzero select, a tick seen while `syncIn` is 1 loads zero instead of incrementing. The counter stays zero on every such tick and resumes counting on the first tick with `syncIn` at 0. A high `syncIn` without a tick leaves the count unchanged.
- R3: With trigger mode 0 and select 0, `syncIn` has no effect on counting. In trigger mode 0, `runStat` stays 0 and `swSetRun` has no effect.
- R4: With trigger mode 1, the counter reads zero while `runStat` is 0. While `runStat` is 1, it rises by one on every tick.
- R5: With trigger mode 1 and a nonzero select, a rising edge of `syncIn` sets `runStat` at the following clock edge. A rising edge means `syncIn` was 0 at the previous clock edge and is 1 at this one. A level that stays high does not set `runStat` again after a software clear.
- R6: `swSetRun` sets `runStat`. `swClrRun` clears `runStat` and zeroes the counter at the next clock edge. When the two arrive together, or a clear arrives with a trigger edge, the clear wins.
- R7: With trigger mode 1 and select 0, edges on `syncIn` never set `runStat`. Only software starts the counter.
- R8: `cascOut` is 1 exactly when the module is on and the counter holds all ones.
- R9: With `cascEn` at 1, the counter advances only on ticks where `cascIn` is 1. Feeding a lower instance's `cascOut` into an upper instance's `cascIn` forms a 2*CNT_W-bit counter that reads the correct tick total.
- R10: While `modOn` is 0, the counter and `runStat` read zero from the next clock edge on, and ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmrTick | input | 1 | One-cycle timer clock enable |
| syncIn | input | 1 | Sync level or trigger source |
| srcSel | input | SEL_W | Source select; nonzero means a source is connected |
| trigMode | input | 1 | 0: level synchronization, 1: edge triggered run latch |
| cascEn | input | 1 | Gate counting with `cascIn` |
| cascIn | input | 1 | Carry in from the lower instance |
| modOn | input | 1 | Module enable; low clears counter and run latch |
| swSetRun | input | 1 | Software set of the run latch |
| swClrRun | input | 1 | Software clear of run latch and counter |
| count | output | CNT_W | Counter value |
| runStat | output | 1 | Run latch state |
| cascOut | output | 1 | High while on and counter is all ones |

## Verification
A wrong run latch shows at `count` on the next tick. The counter either stays at zero when it should run, or moves off zero when it should be held. The latch is also visible directly on `runStat` one edge after the stimulus. A missing edge detector shows as retriggering while `syncIn` stays high after a software clear. A wrong wrap or carry shows at `cascOut` and in the upper half of a chained pair within one tick of the all-ones value. The bench therefore samples right after each edge that follows a stimulus.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
  // strobes from control to datapath for one clock
  typedef struct packed {
    logic clrCnt;   // load zero this edge
    logic incEn;    // add one this edge (ignored when clrCnt)
  } cntCtl_t;
endpackage

// File: rtl/cap_tmr_ctl.sv
module cap_tmr_ctl
  import cap_tmr_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmrTick,
  input  logic             syncIn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             trigMode,
  input  logic             cascEn,
  input  logic             cascIn,
  input  logic             modOn,
  input  logic             swSetRun,
  input  logic             swClrRun,
  output logic             runStat,
  output cntCtl_t          ctl
);
  logic syncPrev;
  logic srcValid;
  logic riseSeen;
  logic runNext;
  logic carryOk;
  logic syncHold;

  assign srcValid = |srcSel;
  assign riseSeen = srcValid & syncIn & ~syncPrev;
  assign carryOk  = ~cascEn | cascIn;
  assign syncHold = ~trigMode & srcValid & syncIn & tmrTick;

  always_comb begin
    if (!modOn || !trigMode)        runNext = 1'b0;
    else if (swClrRun)              runNext = 1'b0;
    else if (swSetRun || riseSeen)  runNext = 1'b1;
    else                            runNext = runStat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncPrev <= 1'b0;
      runStat  <= 1'b0;
    end else begin
      syncPrev <= syncIn;
      runStat  <= runNext;
    end
  end

  always_comb begin
    ctl.clrCnt = ~modOn | (trigMode & (swClrRun | ~runStat)) | syncHold;
    ctl.incEn  = tmrTick & carryOk & (~trigMode | runStat);
  end

  // R5: a qualified rising edge starts the run latch
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (modOn && trigMode && srcValid && syncIn && !syncPrev && !swClrRun) |=> runStat);

  // R6: software clear always wins
  a_r6_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    swClrRun |=> !runStat);

  // R3: latch unused outside trigger mode
  a_r3_latch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trigMode |=> !runStat);
endmodule

// File: rtl/cap_tmr_dp.sv
module cap_tmr_dp
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntCtl_t          ctl,
  input  logic             modOn,
  output logic [CNT_W-1:0] count,
  output logic             cascOut
);
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_VAL = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (ctl.clrCnt) count <= '0;
    else if (ctl.incEn)  count <= count + ONE_VAL;
  end

  assign cascOut = modOn & (count == TOP_VAL);

  // R1: wrap from all ones to zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.incEn && !ctl.clrCnt && count == TOP_VAL) |=> count == '0);

  // R1: no strobe, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.incEn && !ctl.clrCnt) |=> $stable(count));
endmodule

// File: rtl/cap_time_base.sv
module cap_time_base
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmrTick,
  input  logic             syncIn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             trigMode,
  input  logic             cascEn,
  input  logic             cascIn,
  input  logic             modOn,
  input  logic             swSetRun,
  input  logic             swClrRun,
  output logic [CNT_W-1:0] count,
  output logic             runStat,
  output logic             cascOut
);
  cntCtl_t ctl;

  cap_tmr_ctl #(.SEL_W(SEL_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .tmrTick(tmrTick), .syncIn(syncIn),
    .srcSel(srcSel), .trigMode(trigMode), .cascEn(cascEn), .cascIn(cascIn),
    .modOn(modOn), .swSetRun(swSetRun), .swClrRun(swClrRun),
    .runStat(runStat), .ctl(ctl)
  );

  cap_tmr_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .modOn(modOn),
    .count(count), .cascOut(cascOut)
  );

  // R10: off clears counter and latch
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !modOn |=> (count == '0 && !runStat));

  // R4: idle latch holds counter at zero
  a_r4_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (modOn && trigMode && !runStat) |=> count == '0);

  // R2: tick under sync level clears
  a_r2_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (modOn && !trigMode && (|srcSel) && syncIn && tmrTick) |=> count == '0);

  // R8: carry out only while on
  a_r8_casc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !modOn |-> !cascOut);
endmodule

// File: tb/cap_time_base_tb_top.sv
module cap_time_base_tb_top;
  localparam int CW = 16;
  localparam int SW = 5;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmrTick = 0, syncIn = 0, trigMode = 0, cascEn = 0, cascIn = 0;
  logic modOn = 0, swSetRun = 0, swClrRun = 0;
  logic [SW-1:0] srcSel = '0;
  logic [CW-1:0] count;
  logic runStat, cascOut;

  logic chTick = 0, chOn = 0;
  logic [HW-1:0] loCnt, hiCnt;
  logic loRun, hiRun, loCarry, hiCarry;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  cap_time_base #(.CNT_W(CW), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmrTick(tmrTick), .syncIn(syncIn), .srcSel(srcSel),
    .trigMode(trigMode), .cascEn(cascEn), .cascIn(cascIn), .modOn(modOn),
    .swSetRun(swSetRun), .swClrRun(swClrRun), .count(count), .runStat(runStat),
    .cascOut(cascOut)
  );

  cap_time_base #(.CNT_W(HW), .SEL_W(SW)) lo_i (
    .clk(clk), .rst_n(rst_n), .tmrTick(chTick), .syncIn(1'b0), .srcSel('0),
    .trigMode(1'b0), .cascEn(1'b0), .cascIn(1'b0), .modOn(chOn),
    .swSetRun(1'b0), .swClrRun(1'b0), .count(loCnt), .runStat(loRun),
    .cascOut(loCarry)
  );

  cap_time_base #(.CNT_W(HW), .SEL_W(SW)) hi_i (
    .clk(clk), .rst_n(rst_n), .tmrTick(chTick), .syncIn(1'b0), .srcSel('0),
    .trigMode(1'b0), .cascEn(1'b1), .cascIn(loCarry), .modOn(chOn),
    .swSetRun(1'b0), .swClrRun(1'b0), .count(hiCnt), .runStat(hiRun),
    .cascOut(hiCarry)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tmrTick = 1; step();
      tmrTick = 0; step();
    end
  endtask

  task automatic restart();
    modOn = 0; tmrTick = 0; syncIn = 0; swSetRun = 0; swClrRun = 0;
    step();
    modOn = 1;
    step();
  endtask

  task automatic t_reset();
    chk("R10 reset count", count, 0);
    chk("R10 reset runStat", runStat, 0);
    chk("R8 reset cascOut", cascOut, 0);
  endtask

  task automatic t_free_run();
    restart();
    trigMode = 0; srcSel = 0;
    ticks(5);
    chk("R1 five ticks", count, 5);
    step(); step();
    chk("R1 holds without tick", count, 5);
    syncIn = 1;
    ticks(3);
    chk("R3 sync ignored with select 0", count, 8);
    syncIn = 0;
    swSetRun = 1; step(); swSetRun = 0;
    chk("R3 swSet no effect in mode 0", runStat, 0);
  endtask

  task automatic t_sync();
    restart();
    trigMode = 0; srcSel = 5'd3;
    ticks(4);
    chk("R2 counts before sync", count, 4);
    syncIn = 1; step(); step();
    chk("R2 level without tick holds", count, 4);
    ticks(1);
    chk("R2 tick under sync clears", count, 0);
    ticks(2);
    chk("R2 stays zero while high", count, 0);
    syncIn = 0;
    ticks(1);
    chk("R2 resumes after fall", count, 1);
  endtask

  task automatic t_trig();
    restart();
    trigMode = 1; srcSel = 5'd2;
    ticks(3);
    chk("R4 held while latch clear", count, 0);
    syncIn = 1; step();
    chk("R5 edge sets latch", runStat, 1);
    ticks(3);
    chk("R4 counts while latch set", count, 3);
    swClrRun = 1; step(); swClrRun = 0;
    chk("R6 swClr clears count", count, 0);
    chk("R6 swClr clears latch", runStat, 0);
    ticks(2);
    chk("R5 steady level no retrigger", runStat, 0);
    chk("R5 count stays zero", count, 0);
    swSetRun = 1; step(); swSetRun = 0;
    chk("R6 swSet sets latch", runStat, 1);
    ticks(1);
    chk("R6 counts after swSet", count, 1);
    syncIn = 0;
    swSetRun = 1; swClrRun = 1; step(); swSetRun = 0; swClrRun = 0;
    chk("R6 clear wins over set", runStat, 0);
    step();
    syncIn = 1; swClrRun = 1; step(); swClrRun = 0;
    chk("R6 clear wins over edge", runStat, 0);
    syncIn = 0; step();
    srcSel = 0;
    syncIn = 1; step(); step();
    chk("R7 no source, edge ignored", runStat, 0);
    ticks(2);
    chk("R7 counter stays zero", count, 0);
    swSetRun = 1; step(); swSetRun = 0;
    ticks(2);
    chk("R7 software start counts", count, 2);
    syncIn = 0; trigMode = 0;
  endtask

  task automatic t_off();
    restart();
    trigMode = 0; srcSel = 0;
    ticks(6);
    modOn = 0;
    ticks(3);
    chk("R10 off clears and ignores ticks", count, 0);
    chk("R10 off clears latch", runStat, 0);
    modOn = 1; step();
  endtask

  task automatic t_casc();
    restart();
    trigMode = 0; srcSel = 0; cascEn = 1; cascIn = 0;
    ticks(4);
    chk("R9 no carry no count", count, 0);
    cascIn = 1;
    ticks(2);
    chk("R9 carry gated count", count, 2);
    cascIn = 0; cascEn = 0;
  endtask

  task automatic t_wrap();
    restart();
    trigMode = 0; srcSel = 0;
    tmrTick = 1;
    for (int i = 0; i < 65535; i++) @(posedge clk);
    #2;
    tmrTick = 0;
    chk("R1 reaches all ones", count, 16'hFFFF);
    chk("R8 cascOut at all ones", cascOut, 1);
    ticks(1);
    chk("R1 wrap to zero", count, 0);
    chk("R8 cascOut drops", cascOut, 0);
  endtask

  task automatic t_chain();
    chOn = 1; step();
    chTick = 1;
    for (int i = 0; i < 255; i++) @(posedge clk);
    #2;
    chTick = 0;
    chk("R9 low half at top", {hiCnt, loCnt}, 32'h00FF);
    chTick = 1; step(); chTick = 0;
    chk("R9 upper half takes carry", {hiCnt, loCnt}, 32'h0100);
    chTick = 1;
    for (int i = 0; i < 344; i++) @(posedge clk);
    #2;
    chTick = 0;
    chk("R9 combined total 600", {hiCnt, loCnt}, 32'd600);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_free_run();
    t_sync();
    t_trig();
    t_off();
    t_casc();
    t_chain();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule